// File: doc/BRIEF.md
# Profile-Driven Waveform Playback Sequencer

This block replays 32-bit samples held in an internal 1024-word memory. Eight profile slots each hold a start address, a stop address, a step interval, a hold-release bit and a 3-bit mode code. A 3-bit select input chooses the active slot. A prescaler divides the system clock by four to make a sample tick. A per-profile interval timer counts those ticks and moves an up/down address counter. The counter steps once, by one address, every four times M system clocks, where M is the step interval.

Each word read from the memory is steered onto a frequency, phase or amplitude output, or onto both phase and amplitude at once. A 2-bit destination code picks the target. Any output that the current destination does not drive takes its value from a static input. A host port can write and read the memory at any time. A host access stops playback, and playback restarts from the start address once the host access ends. An active-high sweep flag reports the end of a sweep, or each turnaround or wrap in the looping modes.

Top module: `wave_playback_seq`

## Requirements
- R1: Profile slots are written through `prof_we`/`prof_waddr`/`prof_wdata`, with `prof_wdata` laid out as {start[39:30], stop[29:20], step[19:4], hold_release[3], mode[2:0]}. `prof_sel` picks the slot used for playback.
- R2: After a restart the address counter steps once every 4·M system clocks, where M is the step field. A step field of 0 behaves as 1. A word appears on the outputs two clocks after its address is reached.
- R3: Mode codes 000, 101, 110 and 111 are direct mode. Only the word at the start address is applied, the hold-release bit has no effect, and `sweep_done` stays 0.
- R4: Mode 001 counts up from start to stop, then stays at stop. `sweep_done` is 1 while the counter sits at stop.
- R5: In mode 001 with the hold-release bit set, the stop word is shown for one step interval. After that all three outputs return to their static inputs, while `sweep_done` stays 1.
- R6: In mode 010, `prof_sel[0]` sets the direction (1 counts up to stop, 0 counts down to start). The counter halts at the limit, and `sweep_done` is 1 while it sits at the limit it is heading for. A change of `prof_sel[0]` alone only reverses the direction. It does not reload the counter or reset the timer.
- R7: Mode 011 bounces between start and stop without halting. `sweep_done` goes high for 4 clocks at each turnaround.
- R8: Mode 100 counts up to stop and then reloads start on the next step. `sweep_done` goes high for 4 clocks at each wrap.
- R9: The destination code routes the RAM word as follows: 00 sends word[31:0] to `freq_out`; 01 sends word[31:16] to `phase_out`; 10 sends word[31:18] to `amp_out`; 11 sends word[31:16] to `phase_out` and word[15:2] to `amp_out`.
- R10: Each output that the destination does not drive equals its static input, one clock later.
- R11: When `host_en` is high, the RAM is written (if `host_we` is high) and its old word is returned on `host_rdata` one clock later. Playback halts, the outputs go to the static inputs, `sweep_done` goes to 0, and after the access ends playback restarts from the start address.
- R12: When `ram_en` is 0, `sweep_done` is 0 and the outputs follow the static inputs. Raising `ram_en` restarts playback from the start address.
- R13: Any other change of `prof_sel` restarts the prescaler and the timer, and reloads the counter from the new slot.
- R14: During reset all playback outputs and `sweep_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_we | input | 1 | Profile slot write strobe |
| prof_waddr | input | 3 | Profile slot to write |
| prof_wdata | input | 40 | Profile contents (layout in R1) |
| prof_sel | input | 3 | Active profile select |
| ram_en | input | 1 | Playback enable |
| dest_sel | input | 2 | Destination code |
| host_en | input | 1 | Host RAM access strobe |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 10 | Host RAM address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| static_ftw | input | 32 | Static frequency value |
| static_pow | input | 16 | Static phase value |
| static_asf | input | 14 | Static amplitude value |
| freq_out | output | 32 | Frequency parameter |
| phase_out | output | 16 | Phase parameter |
| amp_out | output | 14 | Amplitude parameter |
| sweep_done | output | 1 | End-of-sweep flag |

## Verification
The hardest case to reach is a reversal in mode 010 driven by `prof_sel[0]` alone. A wrong design that reloads the counter on that change can land on the same address as a correct one, so the two only differ in the middle of a sweep. The stimulus therefore stops an upward sweep two steps in, flips bit 0 half an interval before the next step, and samples one step later. At that point a correct design shows the address one below, while a reloading design shows the start address. The short flag pulses of modes 011 and 100 are counted over a fixed window of clocks, which checks both how often they occur and how long each lasts.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned STEP_W = 16;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned PH_W   = DATA_W / 2;
  localparam int unsigned AMP_W  = DATA_W / 2 - 2;
  localparam int unsigned PROF_W = 2 * ADDR_W + STEP_W + 1 + MODE_W;

  typedef enum logic [2:0] {
    M_DIRECT     = 3'd0,
    M_RAMP_UP    = 3'd1,
    M_BIDIR      = 3'd2,
    M_CONT_BIDIR = 3'd3,
    M_RECIRC     = 3'd4
  } play_mode_e;

  typedef enum logic [1:0] {
    D_FREQ  = 2'd0,
    D_PHASE = 2'd1,
    D_AMP   = 2'd2,
    D_POLAR = 2'd3
  } dest_e;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] stop;
    logic [STEP_W-1:0] step;
    logic              hold_rel;
    logic [MODE_W-1:0] mode;
  } prof_t;

  function automatic play_mode_e decode_mode(input logic [MODE_W-1:0] code);
    case (code)
      3'd1:    return M_RAMP_UP;
      3'd2:    return M_BIDIR;
      3'd3:    return M_CONT_BIDIR;
      3'd4:    return M_RECIRC;
      default: return M_DIRECT;
    endcase
  endfunction
endpackage

// File: rtl/wps_prof_bank.sv
module wps_prof_bank
  import wps_pkg::*;
#(
  parameter int unsigned PROF_N = 8,
  localparam int unsigned PSEL_W = $clog2(PROF_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PSEL_W-1:0] waddr,
  input  prof_t             wdata,
  input  logic [PSEL_W-1:0] sel_new,
  output logic [ADDR_W-1:0] new_start,
  output logic [MODE_W-1:0] new_mode,
  input  logic [PSEL_W-1:0] sel_act,
  output prof_t             act_prof
);
  prof_t slots [PROF_N];

  for (genvar i = 0; i < PROF_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slots[i] <= '0;
      else if (we && waddr == PSEL_W'(i)) slots[i] <= wdata;
    end
  end

  assign new_start = slots[sel_new].start;
  assign new_mode  = slots[sel_new].mode;
  assign act_prof  = slots[sel_act];
endmodule

// File: rtl/wps_pacer.sv
module wps_pacer #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned STEP_W   = 16,
  localparam int unsigned DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic [STEP_W-1:0] step,
  output logic              tick,
  output logic              expire
);
  logic [DIV_W-1:0]  div_q;
  logic [STEP_W-1:0] timer_q;
  logic              last;

  assign tick   = run && (div_q == DIV_W'(TICK_DIV - 1));
  assign last   = (step == '0) || (timer_q == step - STEP_W'(1));
  assign expire = tick && last;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q   <= '0;
      timer_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (tick) timer_q <= last ? '0 : timer_q + STEP_W'(1);
    end
  end
endmodule

// File: rtl/wps_wave_ram.sv
module wps_wave_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/wps_router.sv
module wps_router
  import wps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              use_ram,
  input  logic [1:0]        dest,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] s_freq,
  input  logic [PH_W-1:0]   s_phase,
  input  logic [AMP_W-1:0]  s_amp,
  output logic [DATA_W-1:0] freq,
  output logic [PH_W-1:0]   phase,
  output logic [AMP_W-1:0]  amp
);
  dest_e d;
  assign d = dest_e'(dest);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq  <= '0;
      phase <= '0;
      amp   <= '0;
    end else begin
      freq  <= (use_ram && d == D_FREQ) ? word : s_freq;
      phase <= (use_ram && (d == D_PHASE || d == D_POLAR))
               ? word[DATA_W-1 -: PH_W] : s_phase;
      if (use_ram && d == D_AMP)        amp <= word[DATA_W-1 -: AMP_W];
      else if (use_ram && d == D_POLAR) amp <= word[PH_W-1 -: AMP_W];
      else                              amp <= s_amp;
    end
  end
endmodule

// File: rtl/wave_playback_seq.sv
module wave_playback_seq
  import wps_pkg::*;
#(
  parameter int unsigned PROF_N   = 8,
  parameter int unsigned TICK_DIV = 4,
  localparam int unsigned PSEL_W  = $clog2(PROF_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prof_we,
  input  logic [PSEL_W-1:0] prof_waddr,
  input  logic [PROF_W-1:0] prof_wdata,
  input  logic [PSEL_W-1:0] prof_sel,
  input  logic              ram_en,
  input  logic [1:0]        dest_sel,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] static_ftw,
  input  logic [PH_W-1:0]   static_pow,
  input  logic [AMP_W-1:0]  static_asf,
  output logic [DATA_W-1:0] freq_out,
  output logic [PH_W-1:0]   phase_out,
  output logic [AMP_W-1:0]  amp_out,
  output logic              sweep_done
);
  logic [PSEL_W-1:0] act_sel, prev_sel;
  logic [ADDR_W-1:0] new_start, addr;
  logic [MODE_W-1:0] new_mode;
  prof_t             p_act;
  play_mode_e        act_mode;
  logic              need_load, dir_up, pulse, valid, use_q;
  logic              hold, sel_chg, dir_only, restart, run, tick, expire;
  logic              at_lim, done_d;
  logic [DATA_W-1:0] play_word;

  wps_prof_bank #(.PROF_N(PROF_N)) u_bank (
    .clk(clk), .rst(rst), .we(prof_we), .waddr(prof_waddr),
    .wdata(prof_t'(prof_wdata)), .sel_new(prof_sel), .new_start(new_start),
    .new_mode(new_mode), .sel_act(act_sel), .act_prof(p_act)
  );

  assign act_mode = decode_mode(p_act.mode);
  assign hold     = host_en || !ram_en;
  assign sel_chg  = prof_sel != prev_sel;
  assign dir_only = sel_chg && !need_load && act_mode == M_BIDIR
                    && ((prof_sel ^ prev_sel) == PSEL_W'(1));
  assign restart  = !hold && (need_load || (sel_chg && !dir_only));
  assign run      = !hold && !restart;

  wps_pacer #(.TICK_DIV(TICK_DIV), .STEP_W(STEP_W)) u_pacer (
    .clk(clk), .rst(rst), .clear(hold || restart), .run(run),
    .step(p_act.step), .tick(tick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      dir_up    <= 1'b1;
      pulse     <= 1'b0;
      valid     <= 1'b0;
      need_load <= 1'b1;
      prev_sel  <= '0;
      act_sel   <= '0;
    end else begin
      prev_sel <= prof_sel;
      if (hold) begin
        need_load <= 1'b1;
        pulse     <= 1'b0;
      end else if (restart) begin
        need_load <= 1'b0;
        act_sel   <= prof_sel;
        addr      <= new_start;
        dir_up    <= (decode_mode(new_mode) == M_BIDIR) ? prof_sel[0] : 1'b1;
        pulse     <= 1'b0;
        valid     <= 1'b1;
      end else begin
        if (dir_only) dir_up <= prof_sel[0];
        if (tick) pulse <= 1'b0;
        if (expire) begin
          case (act_mode)
            M_RAMP_UP: begin
              if (addr != p_act.stop) addr <= addr + ADDR_W'(1);
              else if (p_act.hold_rel) valid <= 1'b0;
            end
            M_BIDIR: begin
              if (dir_up && addr != p_act.stop) addr <= addr + ADDR_W'(1);
              else if (!dir_up && addr != p_act.start) addr <= addr - ADDR_W'(1);
            end
            M_CONT_BIDIR: begin
              if (dir_up) begin
                if (addr == p_act.stop) begin
                  dir_up <= 1'b0;
                  pulse  <= 1'b1;
                  if (addr != p_act.start) addr <= addr - ADDR_W'(1);
                end else addr <= addr + ADDR_W'(1);
              end else begin
                if (addr == p_act.start) begin
                  dir_up <= 1'b1;
                  pulse  <= 1'b1;
                  if (addr != p_act.stop) addr <= addr + ADDR_W'(1);
                end else addr <= addr - ADDR_W'(1);
              end
            end
            M_RECIRC: begin
              if (addr == p_act.stop) begin
                addr  <= p_act.start;
                pulse <= 1'b1;
              end else addr <= addr + ADDR_W'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign at_lim = dir_up ? (addr == p_act.stop) : (addr == p_act.start);

  always_comb begin
    case (act_mode)
      M_RAMP_UP:    done_d = addr == p_act.stop;
      M_BIDIR:      done_d = at_lim;
      M_CONT_BIDIR: done_d = pulse;
      M_RECIRC:     done_d = pulse;
      default:      done_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_done <= 1'b0;
      use_q      <= 1'b0;
    end else begin
      sweep_done <= run && done_d;
      use_q      <= run && valid;
    end
  end

  wps_wave_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .a_en(host_en), .a_we(host_we), .a_addr(host_addr),
    .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_addr(addr), .b_rdata(play_word)
  );

  wps_router u_route (
    .clk(clk), .rst(rst), .use_ram(use_q), .dest(dest_sel), .word(play_word),
    .s_freq(static_ftw), .s_phase(static_pow), .s_amp(static_asf),
    .freq(freq_out), .phase(phase_out), .amp(amp_out)
  );
endmodule

// File: rtl/wave_playback_seq_chk.sv
module wave_playback_seq_chk
  import wps_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ram_en,
  input logic              host_en,
  input logic [1:0]        dest_sel,
  input logic [DATA_W-1:0] static_ftw,
  input logic [PH_W-1:0]   static_pow,
  input logic [AMP_W-1:0]  static_asf,
  input logic [DATA_W-1:0] freq_out,
  input logic [PH_W-1:0]   phase_out,
  input logic [AMP_W-1:0]  amp_out,
  input logic              sweep_done
);
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk) begin
    if (rst) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end
  assign live = live_cnt == 2'd3;

  a_r12_done_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !ram_en |=> !sweep_done);

  a_r11_done_low_in_host: assert property (@(posedge clk) disable iff (rst)
    host_en |=> !sweep_done);

  a_r12_static_freq_when_off: assert property (@(posedge clk) disable iff (rst)
    !ram_en |=> ##1 (freq_out == $past(static_ftw)));

  a_r10_phase_static_freq_dest: assert property (@(posedge clk) disable iff (rst)
    (live && $past(dest_sel) == 2'b00) |-> (phase_out == $past(static_pow)));

  a_r10_amp_static_phase_dest: assert property (@(posedge clk) disable iff (rst)
    (live && $past(dest_sel) == 2'b01) |-> (amp_out == $past(static_asf)));

  a_r14_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (!sweep_done && freq_out == '0));
endmodule

bind wave_playback_seq wave_playback_seq_chk u_chk (
  .clk(clk), .rst(rst), .ram_en(ram_en), .host_en(host_en),
  .dest_sel(dest_sel), .static_ftw(static_ftw), .static_pow(static_pow),
  .static_asf(static_asf), .freq_out(freq_out), .phase_out(phase_out),
  .amp_out(amp_out), .sweep_done(sweep_done)
);

// File: tb/wave_playback_seq_tb.sv
module wave_playback_seq_tb;
  localparam logic [31:0] FTW = 32'h1234_5678;
  localparam logic [15:0] POW = 16'h4321;
  localparam logic [13:0] ASF = 14'h0555;
  localparam int M = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prof_we = 1'b0;
  logic [2:0]  prof_waddr = '0;
  logic [39:0] prof_wdata = '0;
  logic [2:0]  prof_sel = '0;
  logic        ram_en = 1'b0;
  logic [1:0]  dest_sel = '0;
  logic        host_en = 1'b0, host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [31:0] freq_out;
  logic [15:0] phase_out;
  logic [13:0] amp_out;
  logic        sweep_done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wave_playback_seq u_dut (
    .clk(clk), .rst(rst), .prof_we(prof_we), .prof_waddr(prof_waddr),
    .prof_wdata(prof_wdata), .prof_sel(prof_sel), .ram_en(ram_en),
    .dest_sel(dest_sel), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .static_ftw(FTW), .static_pow(POW), .static_asf(ASF),
    .freq_out(freq_out), .phase_out(phase_out), .amp_out(amp_out),
    .sweep_done(sweep_done)
  );

  typedef struct packed {
    logic [2:0] mode; logic nodw; logic [2:0] sel; logic [1:0] dest;
    logic [9:0] start; logic [9:0] stop; logic [7:0] k;
    logic [9:0] exp_a; logic exp_d;
  } vec_t;

  // R4 R4 R3 R3 R6 R6 R8 R7 R3 R3 ; destinations exercise R9 and R10
  localparam vec_t VEC [10] = '{
    '{3'd1, 1'b0, 3'd0, 2'd0, 10'd5,   10'd9,   8'd2, 10'd7,   1'b0},
    '{3'd1, 1'b0, 3'd1, 2'd1, 10'd5,   10'd9,   8'd8, 10'd9,   1'b1},
    '{3'd0, 1'b0, 3'd2, 2'd2, 10'd20,  10'd30,  8'd3, 10'd20,  1'b0},
    '{3'd6, 1'b1, 3'd3, 2'd3, 10'd40,  10'd45,  8'd5, 10'd40,  1'b0},
    '{3'd2, 1'b0, 3'd5, 2'd0, 10'd100, 10'd103, 8'd6, 10'd103, 1'b1},
    '{3'd2, 1'b0, 3'd2, 2'd0, 10'd100, 10'd103, 8'd2, 10'd100, 1'b1},
    '{3'd4, 1'b0, 3'd6, 2'd1, 10'd50,  10'd52,  8'd4, 10'd51,  1'b0},
    '{3'd3, 1'b0, 3'd7, 2'd0, 10'd60,  10'd62,  8'd3, 10'd61,  1'b0},
    '{3'd5, 1'b0, 3'd4, 2'd0, 10'd10,  10'd12,  8'd2, 10'd10,  1'b0},
    '{3'd7, 1'b0, 3'd0, 2'd3, 10'd11,  10'd14,  8'd4, 10'd11,  1'b0}
  };

  function automatic logic [31:0] wd(input int a);
    logic [9:0] s;
    s = a[9:0];
    return {s, 12'hA5C, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input bit use_ram, input logic [1:0] d, input int a);
    logic [31:0] w;
    w = wd(a);
    chk({tag, " freq"}, freq_out, (use_ram && d == 2'd0) ? w : FTW);
    chk({tag, " phase"}, 32'(phase_out),
        32'((use_ram && (d == 2'd1 || d == 2'd3)) ? w[31:16] : POW));
    chk({tag, " amp"}, 32'(amp_out),
        32'((use_ram && d == 2'd2) ? w[31:18] : (use_ram && d == 2'd3) ? w[15:2] : ASF));
  endtask

  task automatic wr_prof(input int slot, input logic [2:0] mode, input logic nodw,
                         input int start, input int stop, input int step);
    @(negedge clk);
    prof_we = 1'b1; prof_waddr = 3'(slot);
    prof_wdata = {10'(start), 10'(stop), 16'(step), nodw, mode};
    @(negedge clk);
    prof_we = 1'b0;
  endtask

  // After arm, the next rising edge is the restart edge E0.
  task automatic arm(input int sel);
    @(negedge clk); ram_en = 1'b0;
    @(negedge clk); prof_sel = 3'(sel);
    @(negedge clk); ram_en = 1'b1;
  endtask

  // Sample just after edge E_n (counted from E0 or a later restart edge).
  task automatic wait_n(input int n);
    repeat (n + 1) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R14 reset state
    repeat (3) @(negedge clk);
    chk("R14 freq", freq_out, 32'h0);
    chk("R14 phase", 32'(phase_out), 32'h0);
    chk("R14 amp", 32'(amp_out), 32'h0);
    chk("R14 done", 32'(sweep_done), 32'h0);
    rst = 1'b0;

    // fill memory through the host port
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1; host_addr = 10'(a); host_wdata = wd(a);
    end
    @(negedge clk);
    host_we = 1'b0; host_addr = 10'd7;
    @(negedge clk);
    chk("R11 host read", host_rdata, wd(7));
    host_en = 1'b0;

    // R12 outputs static while disabled
    wait_n(3);
    chk_outs("R12 disabled", 1'b0, 2'd0, 0);
    chk("R12 done off", 32'(sweep_done), 32'h0);

    // table walk: R1 profile loading, R2 pacing, mode and routing
    for (int i = 0; i < 10; i++) begin
      string tag;
      tag = $sformatf("R1 vec%0d", i);
      wr_prof(VEC[i].sel, VEC[i].mode, VEC[i].nodw, VEC[i].start, VEC[i].stop, M);
      dest_sel = VEC[i].dest;
      arm(VEC[i].sel);
      wait_n(12 * VEC[i].k + 2 * M);
      chk_outs(tag, 1'b1, VEC[i].dest, VEC[i].exp_a);
      chk({tag, " done"}, 32'(sweep_done), 32'(VEC[i].exp_d));
    end
    dest_sel = 2'd0;

    // R2 step field 0 behaves as 1; other intervals
    wr_prof(1, 3'd1, 1'b0, 0, 9, 0);
    arm(1); wait_n(24);
    chk_outs("R2 step0", 1'b1, 2'd0, 5);
    wr_prof(1, 3'd1, 1'b0, 0, 9, 5);
    arm(1); wait_n(50);
    chk_outs("R2 step5", 1'b1, 2'd0, 2);

    // R5 hold-release in ramp-up
    wr_prof(2, 3'd1, 1'b1, 5, 7, M);
    arm(2); wait_n(30);
    chk_outs("R5 last word", 1'b1, 2'd0, 7);
    repeat (12) @(posedge clk); @(negedge clk);
    chk_outs("R5 released", 1'b0, 2'd0, 7);
    chk("R5 done", 32'(sweep_done), 32'h1);

    // R6 direction flip on select bit 0 without reload
    wr_prof(5, 3'd2, 1'b0, 100, 103, M);
    arm(5); wait_n(30);
    chk_outs("R6 up", 1'b1, 2'd0, 102);
    prof_sel = 3'd4;
    repeat (12) @(posedge clk); @(negedge clk);
    chk_outs("R6 reversed", 1'b1, 2'd0, 101);
    chk("R6 moving", 32'(sweep_done), 32'h0);
    repeat (60) @(posedge clk); @(negedge clk);
    chk_outs("R6 at start", 1'b1, 2'd0, 100);
    chk("R6 done", 32'(sweep_done), 32'h1);

    // R7 turnaround pulses, R8 wrap pulses, R3 no flag
    wr_prof(7, 3'd3, 1'b0, 60, 62, M);
    wr_prof(6, 3'd4, 1'b0, 50, 51, M);
    wr_prof(3, 3'd0, 1'b0, 40, 45, M);
    for (int t = 0; t < 3; t++) begin
      arm(t == 0 ? 7 : t == 1 ? 6 : 3);
      cnt = 0;
      @(posedge clk);
      for (int n = 1; n < 72; n++) begin
        @(posedge clk); @(negedge clk);
        cnt += int'(sweep_done);
      end
      if (t == 0) chk("R7 pulse cycles", 32'(cnt), 32'd8);
      else if (t == 1) chk("R8 pulse cycles", 32'(cnt), 32'd8);
      else chk("R3 no flag", 32'(cnt), 32'd0);
    end

    // R13 select change restarts timer and reloads
    wr_prof(1, 3'd1, 1'b0, 0, 9, M);
    wr_prof(3, 3'd4, 1'b0, 50, 52, M);
    arm(1); wait_n(30);
    chk_outs("R13 before", 1'b1, 2'd0, 2);
    prof_sel = 3'd3;
    wait_n(10);
    chk_outs("R13 reloaded", 1'b1, 2'd0, 50);
    repeat (8) @(posedge clk); @(negedge clk);
    chk_outs("R13 stepped", 1'b1, 2'd0, 51);

    // R11 host access aborts and restarts
    arm(1); wait_n(30);
    host_en = 1'b1; host_we = 1'b0; host_addr = 10'd3;
    repeat (4) @(posedge clk); @(negedge clk);
    chk_outs("R11 halted", 1'b0, 2'd0, 0);
    chk("R11 done low", 32'(sweep_done), 32'h0);
    host_en = 1'b0;
    wait_n(2 * M);
    chk_outs("R11 restart", 1'b1, 2'd0, 0);

    // R12 disable mid-sweep then restart
    wait_n(30);
    ram_en = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    chk_outs("R12 off", 1'b0, 2'd0, 0);
    ram_en = 1'b1;
    wait_n(2 * M);
    chk_outs("R12 restart", 1'b1, 2'd0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule